// File: doc/BRIEF.md
# Dual-Phase Table-Driven PWM Sequencer

This block drives a push-pull pair of PWM outputs from a single up-counter. Every time the counter wraps, a step index advances by one through a sequence that is twice the length of the stored waveform. In the first half of the sequence the lead output takes its duty from the waveform table and the lag output is held at zero duty. In the second half the two swap roles. Both outputs compare against the same counter, so the lag output always runs exactly half a sequence behind the lead output, with no drift and no start-up skew.

Duty values go through a shadow register and reach the active compare only when the counter wraps, so each period has one clean duty. The enable input can switch both outputs to zero duty, but the latched enable is updated only when the step index returns to zero. A drive burst therefore always covers whole waveform cycles. The waveform is held in a small register table with a synchronous write port. A one-clock `pass_end` strobe marks each return of the index to zero.

Top module: `ppwm_top`

## Requirements
- R1: After reset, `pwm_a`, `pwm_b` and `pass_end` are low, the step index is 0 and the latched enable is off. As a result, every period up to and including step position 2H-1 of the first pass has zero duty, whatever `enable` is.
- R2: The counter starts at 0 and increments once per clock. On the clock after it reaches or exceeds `period` it returns to 0, so one PWM period lasts `period`+1 clocks.
- R3: An output is high exactly while the counter is below its active compare value. Within one period it is high for min(duty, `period`+1) clocks: a duty of 0 keeps it low all period, and a duty above `period` keeps it high all period.
- R4: The active compare values change only on the clock edge where the counter wraps. A table write made during a period has no effect on the high time of that period.
- R5: The step index advances by one on each counter wrap and runs through positions 0 to 2H-1, where H is the number of waveform entries. Period k (counting from reset, where period 0 ends at the first wrap) uses step position (k-1) mod 2H.
- R6: At step positions 0 to H-1, `pwm_a` uses waveform entry p and `pwm_b` has zero duty. At positions H to 2H-1, `pwm_b` uses entry p-H and `pwm_a` has zero duty. The two outputs are never high together.
- R7: `enable` is sampled only on the clock edge where the index wraps from 2H-1 to 0. The sampled value applies to all 2H positions of the pass that follows. While the latched value is off, both duties are zero. Changes to `enable` at any other time have no effect.
- R8: `pass_end` is high for exactly one clock: the first clock (counter 0) after the index wraps to 0. This happens once every 2H periods.
- R9: With `wr_en` high and `wr_addr` below H, `wr_data` is written into waveform entry `wr_addr` on the clock edge. After reset, even entries hold 3750 and odd entries hold 11520.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| period | input | W (16) | Last counter value of a PWM period |
| wr_en | input | 1 | Waveform table write strobe |
| wr_addr | input | clog2(H) (3) | Waveform entry to write |
| wr_data | input | W (16) | Duty value to write |
| enable | input | 1 | Requested drive state, taken at pass boundaries |
| pwm_a | output | 1 | Lead PWM output |
| pwm_b | output | 1 | Lag PWM output, half a pass behind |
| pass_end | output | 1 | One-clock strobe after the index wraps to 0 |

## Verification
The bench counts high clocks per period over several passes and targets these corner cases:
- An enable that toggles in the middle of a pass. A design that takes it at once would cut a burst short.
- A table write to the entry whose period is currently active. A design without the shadow stage would change the high time inside that period.
- Duty values of 0 and above the period. An off-by-one in the compare would give a one-clock sliver or a one-clock notch.
- The first pass after reset, which must stay silent even though enable is already high.
- A second run at a long period with the reset contents of the table. This exposes a wrong wrap point, a misplaced `pass_end`, or swapped even and odd default values.

// File: rtl/ppwm_pkg.sv
package ppwm_pkg;

    // Reset contents of the waveform table: alternating low and high duty.
    localparam int DEF_LOW  = 3750;
    localparam int DEF_HIGH = 11520;

    // Which half of the step sequence a channel owns.
    typedef enum logic {
        PH_LEAD = 1'b0,
        PH_LAG  = 1'b1
    } phase_e;

    // Routing of the current table sample toward the channels.
    typedef struct packed {
        logic live;   // latched enable for the running pass
        logic lag;    // index sits in the second half of the sequence
    } route_t;

    function automatic logic [31:0] default_entry(input int i);
        return (i % 2 == 0) ? 32'(DEF_LOW) : 32'(DEF_HIGH);
    endfunction

endpackage

// File: rtl/ppwm_counter.sv
module ppwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    // Wrap on reaching or passing the limit, so lowering the period mid-run
    // never lets the counter run on to its full range.
    assign ovf = (cnt >= period);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ovf) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/ppwm_stepper.sv
module ppwm_stepper #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ovf,
    input  logic          enable,
    output logic [IW-1:0] idx,
    output logic          en_q,
    output logic          pass_end
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic wrap;
    assign wrap = ovf && (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            en_q     <= 1'b0;
            pass_end <= 1'b0;
        end else begin
            pass_end <= wrap;
            if (ovf) begin
                idx <= wrap ? '0 : idx + IW'(1);
            end
            if (wrap) begin
                en_q <= enable;   // enable is committed only between passes
            end
        end
    end

endmodule

// File: rtl/ppwm_wavetable.sv
module ppwm_wavetable #(
    parameter int W    = 16,
    parameter int HALF = 8,
    parameter int TW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [TW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] mem [HALF];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HALF; i++) begin
                mem[i] <= W'(ppwm_pkg::default_entry(i));
            end
        end else if (wr_en && (int'(wr_addr) < HALF)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ppwm_channel.sv
module ppwm_channel #(
    parameter int              W     = 16,
    parameter ppwm_pkg::phase_e PHASE = ppwm_pkg::PH_LEAD
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ovf,
    input  ppwm_pkg::route_t route,
    input  logic [W-1:0]     sample,
    input  logic [W-1:0]     cnt,
    output logic [W-1:0]     act,
    output logic             pwm
);

    logic         mine;
    logic [W-1:0] shadow_q;

    assign mine = route.live && (route.lag == PHASE);

    // Shadow follows the table every clock; active compare takes it at wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            act      <= '0;
        end else begin
            shadow_q <= mine ? sample : '0;
            if (ovf) begin
                act <= shadow_q;
            end
        end
    end

    assign pwm = (cnt < act);

endmodule

// File: rtl/ppwm_top.sv
module ppwm_top #(
    parameter int  W    = 16,
    parameter int  HALF = 8,
    localparam int TW   = $clog2(HALF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  period,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          enable,
    output logic          pwm_a,
    output logic          pwm_b,
    output logic          pass_end
);

    localparam int N  = 2 * HALF;
    localparam int IW = $clog2(N);

    logic [W-1:0]          cnt_q;
    logic                  ovf;
    logic [IW-1:0]         idx;
    logic                  en_q;
    logic [TW-1:0]         rd_idx;
    logic [W-1:0]          sample;
    ppwm_pkg::route_t      route;
    logic [1:0][W-1:0]     cmp_act;
    logic [1:0]            pwm_w;

    ppwm_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .period (period),
        .cnt    (cnt_q),
        .ovf    (ovf)
    );

    ppwm_stepper #(.N(N), .IW(IW)) u_step (
        .clk      (clk),
        .rst      (rst),
        .ovf      (ovf),
        .enable   (enable),
        .idx      (idx),
        .en_q     (en_q),
        .pass_end (pass_end)
    );

    assign route.live = en_q;
    assign route.lag  = (idx >= IW'(HALF));
    assign rd_idx     = route.lag ? TW'(idx - IW'(HALF)) : TW'(idx);

    ppwm_wavetable #(.W(W), .HALF(HALF), .TW(TW)) u_tab (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_idx),
        .rd_data (sample)
    );

    for (genvar c = 0; c < 2; c++) begin : g_ch
        ppwm_channel #(
            .W     (W),
            .PHASE (c == 0 ? ppwm_pkg::PH_LEAD : ppwm_pkg::PH_LAG)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .ovf    (ovf),
            .route  (route),
            .sample (sample),
            .cnt    (cnt_q),
            .act    (cmp_act[c]),
            .pwm    (pwm_w[c])
        );
    end

    assign pwm_a = pwm_w[0];
    assign pwm_b = pwm_w[1];

endmodule

// File: rtl/ppwm_checker.sv
module ppwm_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] period,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_lead,
    input logic [W-1:0] act_lag,
    input logic         en_q,
    input logic         pwm_a,
    input logic         pwm_b,
    input logic         pass_end
);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(pwm_a && pwm_b)); // R6

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt >= period) |=> (cnt == '0)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt < period) |=> (cnt == $past(cnt) + W'(1))); // R2

    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((cnt != '0) && !$past(rst)) |-> ($stable(act_lead) && $stable(act_lag))); // R4

    AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pass_end |=> !pass_end); // R8

    AST_PASS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        pass_end |-> (cnt == '0)); // R8

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pass_end && !$past(rst)) |-> $stable(en_q)); // R7

endmodule

bind ppwm_top ppwm_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .period   (period),
    .cnt      (cnt_q),
    .act_lead (cmp_act[0]),
    .act_lag  (cmp_act[1]),
    .en_q     (en_q),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b),
    .pass_end (pass_end)
);

// File: tb/sim_ppwm_top.sv
module sim_ppwm_top;

    localparam int W    = 16;
    localparam int HALF = 2;
    localparam int P    = 9;        // walk period value: 10 clocks per period
    localparam int PL   = 11000;    // long run period value
    localparam int NV   = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  period = W'(P);
    logic          wr_en = 1'b0;
    logic [0:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic          enable = 1'b0;
    logic          pwm_a, pwm_b, pass_end;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    ppwm_top #(.W(W), .HALF(HALF)) u0 (
        .clk      (clk),
        .rst      (rst),
        .period   (period),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .enable   (enable),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b),
        .pass_end (pass_end)
    );

    // One vector per period: stimulus applied in the period's first clock,
    // expected high clocks of each output and pass_end over the period.
    typedef struct packed {
        logic       we;
        logic [0:0] wa;
        logic [15:0] wd;
        logic       en;
        logic [7:0] ea;
        logic [7:0] eb;
        logic [1:0] ee;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 16'd4,  1'b1, 8'd0,  8'd0,  2'd0}, // P0  R1 nothing active yet
        '{1'b1, 1'b1, 16'd7,  1'b1, 8'd0,  8'd0,  2'd0}, // P1  R1 first pass silent
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd0,  8'd0,  2'd0}, // P2
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd0,  8'd0,  2'd0}, // P3  enable sampled at end
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd0,  8'd0,  2'd1}, // P4  R8 strobe
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd4,  8'd0,  2'd0}, // P5  R5 R6 lead entry0
        '{1'b1, 1'b0, 16'd0,  1'b0, 8'd7,  8'd0,  2'd0}, // P6  lead entry1, R7 disable mid-pass
        '{1'b1, 1'b1, 16'd12, 1'b0, 8'd0,  8'd0,  2'd0}, // P7  R9 lag entry0 = 0
        '{1'b0, 1'b0, 16'd0,  1'b0, 8'd0,  8'd10, 2'd1}, // P8  R3 lag duty 12 > period
        '{1'b0, 1'b0, 16'd0,  1'b0, 8'd0,  8'd0,  2'd0}, // P9  R7 disabled pass
        '{1'b1, 1'b0, 16'd5,  1'b1, 8'd0,  8'd0,  2'd0}, // P10 re-enable requested
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd0,  8'd0,  2'd0}, // P11
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd0,  8'd0,  2'd1}, // P12
        '{1'b0, 1'b0, 16'd0,  1'b0, 8'd5,  8'd0,  2'd0}, // P13 R7 glitch low ignored
        '{1'b1, 1'b1, 16'd3,  1'b1, 8'd10, 8'd0,  2'd0}, // P14 R4 write to active entry
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd0,  8'd5,  2'd0}, // P15
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd0,  8'd3,  2'd1}, // P16 R4 new value next use
        '{1'b0, 1'b0, 16'd0,  1'b1, 8'd5,  8'd0,  2'd0}  // P17 R7 still enabled
    };

    task automatic check(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        #(8 * 200000);
        total++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int ha, hb, he, first_eop, a5, a6, b56, a_early;

        // R1: state during and right after reset
        repeat (4) @(negedge clk);
        #1;
        check("R1 pwm_a in reset", int'(pwm_a), 0);
        check("R1 pwm_b in reset", int'(pwm_b), 0);
        check("R1 pass_end in reset", int'(pass_end), 0);
        @(negedge clk);
        rst = 1'b0;

        // Vector walk: one period per vector
        for (int k = 0; k < NV; k++) begin
            wr_en   = VEC[k].we;
            wr_addr = VEC[k].wa;
            wr_data = VEC[k].wd;
            enable  = VEC[k].en;
            ha = 0; hb = 0; he = 0;
            for (int c = 0; c <= P; c++) begin
                #1;
                ha += int'(pwm_a);
                hb += int'(pwm_b);
                he += int'(pass_end);
                @(negedge clk);
                wr_en = 1'b0;
            end
            check($sformatf("R1/R3/R4/R5/R6/R7 period %0d pwm_a high clocks", k), ha, int'(VEC[k].ea));
            check($sformatf("R1/R3/R4/R5/R6/R7 period %0d pwm_b high clocks", k), hb, int'(VEC[k].eb));
            check($sformatf("R8 period %0d pass_end clocks", k), he, int'(VEC[k].ee));
        end

        // Directed: reset mid-run, long period, reset table contents
        rst    = 1'b1;
        enable = 1'b1;
        period = W'(PL);
        repeat (3) @(negedge clk);
        #1;
        check("R1 pwm_a after mid-run reset", int'(pwm_a), 0);
        check("R1 pwm_b after mid-run reset", int'(pwm_b), 0);
        check("R1 pass_end after mid-run reset", int'(pass_end), 0);
        @(negedge clk);
        rst = 1'b0;

        first_eop = -1; a5 = 0; a6 = 0; b56 = 0; a_early = 0;
        for (int cyc = 0; cyc < 7 * (PL + 1); cyc++) begin
            int per;
            per = cyc / (PL + 1);
            #1;
            if (pass_end && first_eop < 0) first_eop = cyc;
            if (per <= 4) a_early += int'(pwm_a) + int'(pwm_b);
            if (per == 5) a5 += int'(pwm_a);
            if (per == 6) a6 += int'(pwm_a);
            if (per == 5 || per == 6) b56 += int'(pwm_b);
            @(negedge clk);
        end
        check("R2/R8 first pass_end clock index", first_eop, 4 * (PL + 1));
        check("R1 no output during first pass", a_early, 0);
        check("R9/R3 reset entry0 duty in period 5", a5, 3750);
        check("R9/R3 reset entry1 above period in period 6", a6, PL + 1);
        check("R6 lag silent in lead half", b56, 0);

        summary();
        $finish;
    end

endmodule